// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-write sequencer of a byte-wide non-volatile memory controller. It watches each completed byte-write transaction, made of a 15-bit address and an 8-bit data value, and keeps track of whether software write protection is active. For every accepted write it produces one decision: the byte is part of a command sequence, it may be stored, or it must be dropped.

Protection is switched on by a three-byte arming prefix followed by an ordinary data write. A prefix that is not followed by a write leaves protection off. While protection is on, every data write must carry that same prefix or it is dropped. A six-byte release code switches protection off. Command bytes are never passed on for storage.

Each byte of a sequence must arrive within a load window counted in clock cycles from the previous byte. A late byte or a wrong byte cancels the partial sequence. Writes that arrive while the array is busy are not seen at all.

Top module: `wpd_seq_detector`

## Requirements
- R1: After a synchronous active-low reset, `prot_on` is 0 and `dec_valid` is 0.
- R2: Every write taken with `wr_valid`=1 and `busy`=0 yields exactly one `dec_valid` pulse on the next clock. A write presented with `busy`=1 yields no decision and does not move the sequence state.
- R3: While `prot_on`=0, a write that is not part of a command sequence gives `dec_allow`=1 and `dec_cmd`=0.
- R4: The command bytes are reported with `dec_cmd`=1 and `dec_allow`=0. These bytes are data AA at address 5555h, data 55 at 2AAAh, and data A0, 80 or 20 at 5555h, each in its sequence position.
- R5: The arming prefix AA@5555h, 55@2AAAh, A0@5555h, followed by a write to any address, allows that write. `prot_on` becomes 1 in the same cycle as that write's decision.
- R6: If the arming prefix is not followed by a write within the load window, protection stays off. A later write is then treated as plain data.
- R7: While `prot_on`=1, a write without the arming prefix gives `dec_allow`=0 and `dec_cmd`=0.
- R8: While `prot_on`=1, a prefixed write is allowed and `prot_on` stays 1.
- R9: The release code AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 20@5555h reports all six bytes as commands. `prot_on` is 0 from the decision of the sixth byte onward.
- R10: A write that does not match the expected next step cancels the partial sequence. That write is then handled as data: allowed when unprotected, dropped when protected. Matching starts again from the first step.
- R11: A gap of more than `WINDOW_CYC` clock cycles between two writes of a sequence cancels it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle pulse marking a completed byte write |
| wr_addr | input | 15 | Address of the write |
| wr_data | input | 8 | Data of the write |
| busy | input | 1 | Array is programming; writes are ignored |
| prot_on | output | 1 | Software write protection is active |
| dec_valid | output | 1 | Decision for the previous accepted write is present |
| dec_allow | output | 1 | The byte may be stored in the array |
| dec_cmd | output | 1 | The byte was consumed as a command byte |

## Verification
The bench drives plain writes, full arming and release codes, and prefixed and unprefixed writes in both protection states. This separates the data-allowed, dropped and command verdicts, and it shows the exact decision on which `prot_on` changes. Broken sequences are tried as well: a wrong third byte, a lone second byte, a prefix with no data write, and a gap longer than the window. These show that a cancelled sequence falls back to data handling and restarts from the first step. A write issued while busy sits in the middle of a prefix, and the prefix must still complete around it. This shows that busy traffic leaves the state untouched.

// File: rtl/wpd_pkg.sv
// Shared widths, sequence states and command constants for the
// write-protect sequence detector.
package wpd_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // no partial sequence
        ST_K1,     // first key seen
        ST_K2,     // second key seen
        ST_ARM,    // arming prefix complete, waiting for data write
        ST_R3,     // release opcode seen
        ST_R4,     // release: first key again
        ST_R5      // release: second key again
    } wpd_state_t;

    localparam logic [ADDR_W-1:0] ADDR_KEY_A = 15'h5555;
    localparam logic [ADDR_W-1:0] ADDR_KEY_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] OP_ARM     = 8'hA0;
    localparam logic [DATA_W-1:0] OP_RELEASE = 8'h80;
    localparam logic [DATA_W-1:0] OP_FINAL   = 8'h20;
endpackage

// File: rtl/wpd_step_match.sv
// Combinational step matcher. Given the current sequence state and
// one write, it says whether the write is the expected next command
// byte and which state follows. It assumes the caller handles the
// armed state (any write completes it) separately.
module wpd_step_match
    import wpd_pkg::*;
(
    input  wpd_state_t            cur_state,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    output logic                  hit,
    output wpd_state_t            nxt_state,
    output logic                  release_done
);
    logic at_a, at_b;

    // Address decode against the two key addresses.
    always_comb begin
        at_a = (addr == ADDR_KEY_A);
        at_b = (addr == ADDR_KEY_B);
    end

    // Expected-step table for every non-armed state.
    always_comb begin
        hit          = 1'b0;
        nxt_state    = ST_IDLE;
        release_done = 1'b0;
        unique case (cur_state)
            ST_IDLE: if (at_a && data == KEY_FIRST) begin
                hit = 1'b1; nxt_state = ST_K1;
            end
            ST_K1: if (at_b && data == KEY_SECOND) begin
                hit = 1'b1; nxt_state = ST_K2;
            end
            ST_K2: begin
                if (at_a && data == OP_ARM) begin
                    hit = 1'b1; nxt_state = ST_ARM;
                end else if (at_a && data == OP_RELEASE) begin
                    hit = 1'b1; nxt_state = ST_R3;
                end
            end
            ST_R3: if (at_a && data == KEY_FIRST) begin
                hit = 1'b1; nxt_state = ST_R4;
            end
            ST_R4: if (at_b && data == KEY_SECOND) begin
                hit = 1'b1; nxt_state = ST_R5;
            end
            ST_R5: if (at_a && data == OP_FINAL) begin
                hit = 1'b1; nxt_state = ST_IDLE; release_done = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/wpd_load_window.sv
// Byte-load window timer. Restarts on every accepted write and counts
// while a partial sequence is open; flags expiry once WINDOW_CYC
// cycles have passed with no further write. Assumes WINDOW_CYC >= 2.
module wpd_load_window #(
    parameter int WINDOW_CYC = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WINDOW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

    logic [CW-1:0] cnt;

    // Cycle counter since the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (kick)   cnt <= '0;
        else if (run)    cnt <= cnt + 1'b1;
    end

    // Expiry when the window is used up and no write arrives now.
    always_comb expired = run && !kick && (cnt >= LAST);

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WINDOW_CYC)) else $error("window counter overran"); // R11
endmodule

// File: rtl/wpd_seq_detector.sv
// Write-protect command sequence detector (top). Watches completed
// byte writes, tracks the protection state, and gives one registered
// verdict per accepted write: command, allow or drop. Assumes
// wr_valid is a single-cycle pulse per write and that busy writes
// must be ignored entirely.
module wpd_seq_detector
    import wpd_pkg::*;
#(
    parameter int WINDOW_CYC = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prot_on,
    output logic              dec_valid,
    output logic              dec_allow,
    output logic              dec_cmd
);
    wpd_state_t state, step_nxt;
    logic take, step_hit, step_release, win_expired;

    // A write counts only when the array is not busy.
    always_comb take = wr_valid && !busy;

    wpd_step_match u_match (
        .cur_state    (state),
        .addr         (wr_addr),
        .data         (wr_data),
        .hit          (step_hit),
        .nxt_state    (step_nxt),
        .release_done (step_release)
    );

    wpd_load_window #(.WINDOW_CYC(WINDOW_CYC)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (take),
        .run     (state != ST_IDLE),
        .expired (win_expired)
    );

    // Sequence state, protection flag and per-write verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            prot_on   <= 1'b0;
            dec_valid <= 1'b0;
            dec_allow <= 1'b0;
            dec_cmd   <= 1'b0;
        end else begin
            dec_valid <= take;
            dec_allow <= 1'b0;
            dec_cmd   <= 1'b0;
            if (take) begin
                if (state == ST_ARM) begin
                    dec_allow <= 1'b1;
                    prot_on   <= 1'b1;
                    state     <= ST_IDLE;
                end else if (step_hit) begin
                    dec_cmd <= 1'b1;
                    state   <= step_nxt;
                    if (step_release) prot_on <= 1'b0;
                end else begin
                    dec_allow <= !prot_on;
                    state     <= ST_IDLE;
                end
            end else if (win_expired) begin
                state <= ST_IDLE;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!prot_on && !dec_valid)) else $error("reset state"); // R1
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && busy) |=> !dec_valid) else $error("busy write decided"); // R2
    AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_cmd) |-> !dec_allow) else $error("command stored"); // R4
    AST_ARM_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> (dec_valid && dec_allow && !dec_cmd)) else $error("bad enable"); // R5
    AST_RELEASE_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> (dec_valid && dec_cmd)) else $error("bad release"); // R9
    AST_QUIET_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(prot_on)) else $error("prot moved without write"); // R6
endmodule

// File: tb/sim_wpd_seq_detector.sv
module sim_wpd_seq_detector;
    localparam int WIN = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        prot_on, dec_valid, dec_allow, dec_cmd;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic  allow;
        logic  cmd;
        logic  prot;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    wpd_seq_detector #(.WINDOW_CYC(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .prot_on(prot_on),
        .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_cmd(dec_cmd)
    );

    // Driver: one write pulse, expected verdict queued.
    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input logic ea, input logic ec, input logic ep, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = 1'b0;
        e.allow = ea; e.cmd = ec; e.prot = ep; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Driver: write presented while busy, no verdict expected.
    task automatic wr_busy(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; busy = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input logic [14:0] a, input logic [7:0] d, input logic ep, input string tag);
        wr(a, d, 1'b0, 1'b1, ep, tag);
    endtask

    // Monitor: pop and compare every verdict.
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            vectors++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected verdict: actual=dec_valid expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (dec_allow !== e.allow || dec_cmd !== e.cmd || prot_on !== e.prot) begin
                    fails++;
                    $display("FAIL %s: actual allow=%b cmd=%b prot=%b expected allow=%b cmd=%b prot=%b",
                             e.tag, dec_allow, dec_cmd, prot_on, e.allow, e.cmd, e.prot);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        vectors++;
        if (prot_on !== 1'b0 || dec_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual prot=%b valid=%b expected prot=0 valid=0", prot_on, dec_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        wr(15'h0123, 8'h5A, 1, 0, 0, "R3 plain write");
        wr(15'h5555, 8'h11, 1, 0, 0, "R3 key addr other data");

        // busy write in the middle of a prefix is invisible
        cmd(15'h5555, 8'hAA, 0, "R4 key1");
        wr_busy(15'h0000, 8'h12);
        cmd(15'h2AAA, 8'h55, 0, "R2 key2 after busy");
        wr(15'h0000, 8'h77, 1, 0, 0, "R10 wrong third byte is data");
        wr(15'h2AAA, 8'h55, 1, 0, 0, "R10 lone key2 restarts");

        // arming prefix with no follow-up write
        cmd(15'h5555, 8'hAA, 0, "R4 key1");
        cmd(15'h2AAA, 8'h55, 0, "R4 key2");
        cmd(15'h5555, 8'hA0, 0, "R4 arm op");
        idle(WIN + 5);
        wr(15'h0200, 8'h33, 1, 0, 0, "R6 late write stays unprotected");

        // window expiry between key bytes
        cmd(15'h5555, 8'hAA, 0, "R11 key1");
        idle(WIN + 5);
        wr(15'h2AAA, 8'h55, 1, 0, 0, "R11 late key2 is data");
        cmd(15'h5555, 8'hAA, 0, "R11 key1");
        idle(WIN - 8);
        cmd(15'h2AAA, 8'h55, 0, "R11 key2 in window");
        wr(15'h0010, 8'h01, 1, 0, 0, "R10 abort after key2");

        // enable protection
        cmd(15'h5555, 8'hAA, 0, "R5 key1");
        cmd(15'h2AAA, 8'h55, 0, "R5 key2");
        cmd(15'h5555, 8'hA0, 0, "R5 arm op");
        wr(15'h0300, 8'h44, 1, 0, 1, "R5 armed write enables");
        wr(15'h0301, 8'h45, 0, 0, 1, "R7 unprefixed blocked");
        cmd(15'h5555, 8'hAA, 1, "R8 key1");
        cmd(15'h2AAA, 8'h55, 1, "R8 key2");
        cmd(15'h5555, 8'hA0, 1, "R8 arm op");
        wr(15'h0302, 8'h46, 1, 0, 1, "R8 prefixed allowed");
        cmd(15'h5555, 8'hAA, 1, "R10 key1");
        wr(15'h5555, 8'h66, 0, 0, 1, "R10 mismatch blocked when protected");

        // release code
        cmd(15'h5555, 8'hAA, 1, "R9 b1");
        cmd(15'h2AAA, 8'h55, 1, "R9 b2");
        cmd(15'h5555, 8'h80, 1, "R9 b3");
        cmd(15'h5555, 8'hAA, 1, "R9 b4");
        cmd(15'h2AAA, 8'h55, 1, "R9 b5");
        cmd(15'h5555, 8'h20, 0, "R9 b6 clears");
        wr(15'h0400, 8'h99, 1, 0, 0, "R3 write after release");

        // release code while unprotected
        cmd(15'h5555, 8'hAA, 0, "R9 u1");
        cmd(15'h2AAA, 8'h55, 0, "R9 u2");
        cmd(15'h5555, 8'h80, 0, "R9 u3");
        cmd(15'h5555, 8'hAA, 0, "R9 u4");
        cmd(15'h2AAA, 8'h55, 0, "R9 u5");
        cmd(15'h5555, 8'h20, 0, "R9 u6");
        wr(15'h0401, 8'h98, 1, 0, 0, "R3 still unprotected");

        idle(4);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing verdicts: actual=%0d pending expected=0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule